// File: doc/BRIEF.md
# Cache Block Refill Engine with Selectable Memory Organization

When a cache misses, this engine brings the missing block in from main memory and hands it to the cache one word per clock, with each word tagged by its position in the block. It accepts a miss address while idle, drives the address and access-start strobes toward the memory banks, and times each access with its own down-counter. Each word that a bank delivers goes out on the fill port. A strobe marks the final word. The number of clocks the refill took is then held on a penalty output.

A build-time parameter picks the memory organization. The first option is one bank with a full access for every word. The second is one bank where only the first access is full length and later words in the same row use a shorter access. The third is one bank per word, all started together, with the words then returned on consecutive clocks. Block size, word width, access times and the penalty width are also parameters. The memory banks sit outside the block: each bank latches the address presented while its start strobe is high and later drives its read-data lane.

Top module: `refill_engine`

## Requirements
- R1: After reset, miss_ready is 1, fill_valid and fill_done are 0, and penalty is 0.
- R2: A miss is accepted only on a clock edge where miss_valid and miss_ready are both 1. miss_ready is 0 from the cycle after acceptance until the refill ends, and miss_valid pulses during that time produce no extra fill words and leave the penalty unchanged.
- R3: The block base is miss_addr with its low log2(BLOCK_WORDS*DATA_W/8) bits forced to zero. Fill word i carries the memory word at byte address base + i*DATA_W/8.
- R4: Fill words appear in ascending index order from 0 to BLOCK_WORDS-1. Each word has fill_valid high for exactly one cycle, and fill_index gives its position.
- R5: ORG=0 (single bank, full access each word): counting cycle 1 as the cycle after the accepting edge, word i appears in cycle 1 + T_ACCESS*(i+1) + 1. With the default timing this is a penalty of 102 for four words and 27 for one word.
- R6: ORG=1 (page mode): word i appears in cycle 1 + T_ACCESS + T_PAGE*i + 1, which gives a penalty of 51 for four words at the default timing.
- R7: ORG=2 (interleaved, one bank per word): all banks start together and word i appears in cycle 1 + T_ACCESS + i + 1, which gives a penalty of 30 for four words.
- R8: fill_done is high in the same cycle as the last word's fill_valid, and miss_ready is 1 in the following cycle.
- R9: In the cycle after fill_done, penalty equals the cycle number of the last word. It holds that value until the next refill ends.
- R10: The engine starts an access by raising mem_start for one cycle, with mem_addr giving the byte address of the word that bank 0 must fetch. Bank b fetches mem_addr + b*DATA_W/8 and drives it on lane b of mem_rdata until its next start. Single-bank modes raise mem_start once per word. Interleaved mode raises every bit at once, a single time per refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request |
| miss_addr | input | ADDR_W | Byte address that missed |
| miss_ready | output | 1 | Engine idle, can take a miss |
| mem_start | output | BANKS | Per-bank access start strobe |
| mem_addr | output | ADDR_W | Byte address for bank 0's access |
| mem_rdata | input | BANKS*DATA_W | Read data, lane b from bank b |
| fill_valid | output | 1 | Fill word strobe |
| fill_index | output | IDX_W | Position of the fill word in the block |
| fill_data | output | DATA_W | Fill word |
| fill_done | output | 1 | Last word of the block |
| penalty | output | PENALTY_W | Clocks taken by the last completed refill |

## Verification
The bench builds four copies side by side, all with the default 25-clock full access and 8-clock page access. Three of them use four-word blocks, one for each organization, so the 102, 51 and 30 clock penalties and the word spacing of each mode are compared on the same stimulus. The fourth is a single-bank copy with a one-word block, which covers the case where the first word is also the last one (a 27 clock refill, with fill_done on index 0). Unaligned and top-of-space miss addresses check the alignment. Requests sent while the copies are busy check that such requests are ignored.

// File: rtl/refill_pkg.sv
// Shared types for the refill engine: memory organization selector and
// control states. Assumes nothing beyond IEEE 1800-2017 elaboration.
package refill_pkg;

    typedef enum logic [1:0] {
        ORG_SINGLE      = 2'd0,
        ORG_PAGE        = 2'd1,
        ORG_INTERLEAVED = 2'd2
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DRAIN
    } state_e;

    // Number of banks the chosen organization needs for a block.
    function automatic int bank_count(org_e org, int words);
        return (org == ORG_INTERLEAVED) ? words : 1;
    endfunction

    // Bits needed to hold a word position (at least one).
    function automatic int index_width(int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

endpackage

// File: rtl/refill_bank_timer.sv
// Access timer of one memory bank. A load pulse arms it with the access
// length; it counts down and flags the final cycle of the access, the
// cycle in which the bank's read data is valid and gets captured.
// Assumes load_len >= 1 and that load may coincide with fin (back-to-back).
module refill_bank_timer #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    output logic             fin
);

    logic [LEN_W-1:0] remain;

    // Down-counter: reload on start, otherwise count the access down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_len;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Last cycle of the access.
    assign fin = (remain == LEN_W'(1));

endmodule

// File: rtl/refill_seq.sv
// Refill control. Takes a miss when idle, sends the address for one cycle,
// starts bank accesses, and in the single-bank organizations launches the
// next word's access in the same cycle the previous one finishes, so the
// bus return of one word overlaps the next access. Assumes all banks are
// loaded together so a single combined finish flag suffices.
module refill_seq
    import refill_pkg::*;
#(
    parameter org_e ORG      = ORG_SINGLE,
    parameter int   WORDS    = 4,
    parameter int   T_ACCESS = 25,
    parameter int   T_PAGE   = 8,
    parameter int   LEN_W    = 5,
    parameter int   IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic             fin_all,
    input  logic             fill_done,
    output logic             miss_ready,
    output logic             accept,
    output logic             busy,
    output logic             load,
    output logic [LEN_W-1:0] load_len,
    output logic [IDX_W-1:0] issue_idx,
    output logic [IDX_W-1:0] acc_ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(WORDS - 1);
    localparam logic [LEN_W-1:0] LEN_FIRST = LEN_W'(T_ACCESS);
    localparam logic [LEN_W-1:0] LEN_NEXT  =
        (ORG == ORG_PAGE) ? LEN_W'(T_PAGE) : LEN_W'(T_ACCESS);

    state_e state, state_nx;
    logic   last_access;

    // Interleaved mode fetches everything in one access round.
    assign last_access = (ORG == ORG_INTERLEAVED) || (acc_ptr == LAST_IDX);
    assign busy        = (state != ST_IDLE);

    // Next-state and strobe decode.
    always_comb begin
        state_nx   = state;
        miss_ready = 1'b0;
        accept     = 1'b0;
        load       = 1'b0;
        load_len   = LEN_FIRST;
        issue_idx  = '0;
        case (state)
            ST_IDLE: begin
                miss_ready = 1'b1;
                if (miss_valid) begin
                    accept   = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                load     = 1'b1;
                state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (fin_all) begin
                    if (last_access) begin
                        state_nx = ST_DRAIN;
                    end else begin
                        load      = 1'b1;
                        load_len  = LEN_NEXT;
                        issue_idx = acc_ptr + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (fill_done) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Index of the word whose access is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ptr <= '0;
        end else if (accept) begin
            acc_ptr <= '0;
        end else if ((state == ST_WAIT) && fin_all && !last_access) begin
            acc_ptr <= acc_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/refill_return.sv
// Word return path. Captures bank data in the final access cycle and
// presents it on the one-word bus in the next cycle. In interleaved mode
// all lanes are captured at once and then walked out one per cycle.
// Assumes BANKS == WORDS in interleaved mode and BANKS == 1 otherwise.
module refill_return
    import refill_pkg::*;
#(
    parameter org_e ORG    = ORG_SINGLE,
    parameter int   WORDS  = 4,
    parameter int   BANKS  = 1,
    parameter int   DATA_W = 32,
    parameter int   IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fin_all,
    input  logic [IDX_W-1:0]        acc_ptr,
    input  logic [BANKS*DATA_W-1:0] bank_rdata,
    output logic                    fill_valid,
    output logic [IDX_W-1:0]        fill_index,
    output logic [DATA_W-1:0]       fill_data,
    output logic                    fill_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic              valid_q;
    logic [IDX_W-1:0]  idx_q;

    generate
        if (ORG == ORG_INTERLEAVED) begin : g_walk
            logic [DATA_W-1:0] hold [BANKS];

            // Capture every bank lane when the common access ends.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int b = 0; b < BANKS; b++) hold[b] <= '0;
                end else if (fin_all) begin
                    for (int b = 0; b < BANKS; b++)
                        hold[b] <= bank_rdata[b*DATA_W +: DATA_W];
                end
            end

            // Walk the captured words out, one per cycle, from index 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    idx_q   <= '0;
                end else if (fin_all) begin
                    valid_q <= 1'b1;
                    idx_q   <= acc_ptr;
                end else if (valid_q && (idx_q != LAST_IDX)) begin
                    valid_q <= 1'b1;
                    idx_q   <= idx_q + 1'b1;
                end else begin
                    valid_q <= 1'b0;
                end
            end

            assign fill_data = hold[idx_q];
        end else begin : g_serial
            logic [DATA_W-1:0] hold;

            // Capture the single bank's word when its access ends.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold <= '0;
                end else if (fin_all) begin
                    hold <= bank_rdata[DATA_W-1:0];
                end
            end

            // One-cycle strobe tagged with the finished word's index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    idx_q   <= '0;
                end else begin
                    valid_q <= fin_all;
                    if (fin_all) idx_q <= acc_ptr;
                end
            end

            assign fill_data = hold;
        end
    endgenerate

    assign fill_valid = valid_q;
    assign fill_index = idx_q;
    assign fill_done  = valid_q && (idx_q == LAST_IDX);

endmodule

// File: rtl/refill_cycle_counter.sv
// Miss penalty measurement. Counts 1 in the cycle after acceptance and one
// more each busy cycle; the value in the last-word cycle is latched as the
// penalty. Assumes PENALTY_W covers the slowest organization.
module refill_cycle_counter #(
    parameter int PENALTY_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 busy,
    input  logic                 done,
    output logic [PENALTY_W-1:0] penalty
);

    logic [PENALTY_W-1:0] elapsed;

    // Running count of refill cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (accept) begin
            elapsed <= PENALTY_W'(1);
        end else if (busy) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Hold the count seen in the final word's cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            penalty <= '0;
        end else if (done) begin
            penalty <= elapsed;
        end
    end

endmodule

// File: rtl/refill_engine.sv
// Cache block refill engine. Aligns the miss address to the block, drives
// bank start strobes and addresses, times each bank with its own counter,
// returns words one per clock and reports the refill length in cycles.
// Assumes external banks latch mem_addr (+ lane offset) on their start
// strobe and hold their read lane until the next start.
module refill_engine
    import refill_pkg::*;
#(
    parameter org_e ORG         = ORG_SINGLE,
    parameter int   BLOCK_WORDS = 4,
    parameter int   DATA_W      = 32,
    parameter int   ADDR_W      = 32,
    parameter int   T_ACCESS    = 25,
    parameter int   T_PAGE      = 8,
    parameter int   PENALTY_W   = 16,
    localparam int  BANKS       = bank_count(ORG, BLOCK_WORDS),
    localparam int  IDX_W       = index_width(BLOCK_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_addr,
    output logic                    miss_ready,
    output logic [BANKS-1:0]        mem_start,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [BANKS*DATA_W-1:0] mem_rdata,
    output logic                    fill_valid,
    output logic [IDX_W-1:0]        fill_index,
    output logic [DATA_W-1:0]       fill_data,
    output logic                    fill_done,
    output logic [PENALTY_W-1:0]    penalty
);

    localparam int T_MAX      = (T_ACCESS > T_PAGE) ? T_ACCESS : T_PAGE;
    localparam int LEN_W      = $clog2(T_MAX + 1);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BYTE_SH    = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] BLOCK_MASK = ADDR_W'(BLOCK_WORDS * WORD_BYTES - 1);

    logic             accept;
    logic             busy;
    logic             load;
    logic [LEN_W-1:0] load_len;
    logic [IDX_W-1:0] issue_idx;
    logic [IDX_W-1:0] acc_ptr;
    logic [BANKS-1:0] bank_fin;
    logic             fin_all;
    logic [ADDR_W-1:0] block_base;

    // Block-aligned base address captured with the miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_base <= '0;
        end else if (accept) begin
            block_base <= miss_addr & ~BLOCK_MASK;
        end
    end

    assign mem_addr  = block_base + (ADDR_W'(issue_idx) << BYTE_SH);
    assign mem_start = {BANKS{load}};
    assign fin_all   = &bank_fin;

    refill_seq #(
        .ORG      (ORG),
        .WORDS    (BLOCK_WORDS),
        .T_ACCESS (T_ACCESS),
        .T_PAGE   (T_PAGE),
        .LEN_W    (LEN_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .fin_all    (fin_all),
        .fill_done  (fill_done),
        .miss_ready (miss_ready),
        .accept     (accept),
        .busy       (busy),
        .load       (load),
        .load_len   (load_len),
        .issue_idx  (issue_idx),
        .acc_ptr    (acc_ptr)
    );

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            refill_bank_timer #(
                .LEN_W (LEN_W)
            ) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (mem_start[b]),
                .load_len (load_len),
                .fin      (bank_fin[b])
            );
        end
    endgenerate

    refill_return #(
        .ORG    (ORG),
        .WORDS  (BLOCK_WORDS),
        .BANKS  (BANKS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_return (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_all    (fin_all),
        .acc_ptr    (acc_ptr),
        .bank_rdata (mem_rdata),
        .fill_valid (fill_valid),
        .fill_index (fill_index),
        .fill_data  (fill_data),
        .fill_done  (fill_done)
    );

    refill_cycle_counter #(
        .PENALTY_W (PENALTY_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .busy    (busy),
        .done    (fill_done),
        .penalty (penalty)
    );

endmodule

// File: rtl/refill_engine_checker.sv
// Protocol and timing properties of the refill engine, watched from its
// ports with an independent cycle count of its own. Bound to every
// instance of refill_engine.
module refill_engine_checker #(
    parameter int BANKS     = 1,
    parameter int IDX_W     = 2,
    parameter int PENALTY_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 miss_valid,
    input logic                 miss_ready,
    input logic [BANKS-1:0]     mem_start,
    input logic                 fill_valid,
    input logic [IDX_W-1:0]     fill_index,
    input logic                 fill_done,
    input logic [PENALTY_W-1:0] penalty
);

    logic [PENALTY_W-1:0] chk_cnt;

    // Own count of cycles since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cnt <= '0;
        end else if (miss_valid && miss_ready) begin
            chk_cnt <= PENALTY_W'(1);
        end else if (!miss_ready) begin
            chk_cnt <= chk_cnt + 1'b1;
        end
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);

    assert_not_ready_while_filling_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !miss_ready);

    assert_index_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && $past(fill_valid)) |-> (fill_index == IDX_W'($past(fill_index) + 1'b1)));

    assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> miss_ready);

    assert_penalty_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (penalty == $past(chk_cnt)));

    assert_penalty_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_done && !$past(fill_done)) |-> $stable(penalty));

    assert_banks_together_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_start != '0) |-> (mem_start == '1));

endmodule

bind refill_engine refill_engine_checker #(
    .BANKS     (BANKS),
    .IDX_W     (IDX_W),
    .PENALTY_W (PENALTY_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .mem_start  (mem_start),
    .fill_valid (fill_valid),
    .fill_index (fill_index),
    .fill_done  (fill_done),
    .penalty    (penalty)
);

// File: tb/refill_engine_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: four engine copies (single, page, interleaved with four
// words; single with one word) share the miss stimulus. The driver pushes
// expected words with their expected cycle into a per-copy queue; a monitor
// per copy pops and compares as words come out.
module refill_engine_bench;
    import refill_pkg::*;

    localparam int NL = 4;

    typedef struct {
        int          idx;
        logic [31:0] data;
        int          cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic [NL-1:0] lane_ready;

    exp_t exp_q [NL][$];
    int   exp_pen [NL];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic org_e lane_org(int l);
        case (l)
            1:       return ORG_PAGE;
            2:       return ORG_INTERLEAVED;
            default: return ORG_SINGLE;
        endcase
    endfunction

    function automatic int lane_words(int l);
        return (l == 3) ? 1 : 4;
    endfunction

    // Cycle of word i counted from the accepting edge (R5, R6, R7).
    function automatic int word_cycle(org_e o, int i);
        case (o)
            ORG_PAGE:        return 1 + 25 + 8 * i + 1;
            ORG_INTERLEAVED: return 1 + 25 + i + 1;
            default:         return 1 + 25 * (i + 1) + 1;
        endcase
    endfunction

    function automatic string timing_tag(org_e o);
        case (o)
            ORG_PAGE:        return "R6";
            ORG_INTERLEAVED: return "R7";
            default:         return "R5";
        endcase
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    generate
        for (genvar L = 0; L < NL; L++) begin : g_lane
            localparam org_e ORG = lane_org(L);
            localparam int   W   = lane_words(L);
            localparam int   NB  = (ORG == ORG_INTERLEAVED) ? W : 1;
            localparam int   IW  = (W > 1) ? $clog2(W) : 1;

            logic              ready;
            logic [NB-1:0]     mstart;
            logic [31:0]       maddr;
            logic [NB*32-1:0]  rdata;
            logic              fvalid;
            logic [IW-1:0]     fidx;
            logic [31:0]       fdata;
            logic              fdone;
            logic [15:0]       pen;
            logic [31:0]       lat [NB];

            assign lane_ready[L] = ready;

            // Bank model: latch the address on start, serve the word from it (R10).
            always_ff @(posedge clk) begin
                for (int b = 0; b < NB; b++)
                    if (mstart[b]) lat[b] <= maddr + 32'(4 * b);
            end
            always_comb begin
                for (int b = 0; b < NB; b++) rdata[b*32 +: 32] = mem_word(lat[b]);
            end

            refill_engine #(
                .ORG         (ORG),
                .BLOCK_WORDS (W)
            ) u_refill_engine (
                .clk        (clk),
                .rst_n      (rst_n),
                .miss_valid (miss_valid),
                .miss_addr  (miss_addr),
                .miss_ready (ready),
                .mem_start  (mstart),
                .mem_addr   (maddr),
                .mem_rdata  (rdata),
                .fill_valid (fvalid),
                .fill_index (fidx),
                .fill_data  (fdata),
                .fill_done  (fdone),
                .penalty    (pen)
            );

            // R1: state right after reset release.
            initial begin
                @(posedge rst_n);
                @(negedge clk);
                check(ready == 1'b1, "R1", $sformatf("lane%0d miss_ready", L), ready, 1);
                check(fvalid == 1'b0 && fdone == 1'b0, "R1",
                      $sformatf("lane%0d fill strobes", L), {fvalid, fdone}, 0);
                check(pen == 16'd0, "R1", $sformatf("lane%0d penalty", L), pen, 0);
            end

            // Monitor: pop expected words and compare at mid-cycle.
            int cyc    = 0;
            int starts = 0;
            bit pend   = 1'b0;
            always @(negedge clk) begin
                exp_t e;
                if (rst_n) begin
                    cyc++;
                    if (mstart != '0) begin
                        starts++;
                        check(mstart == '1, "R10", $sformatf("lane%0d start lanes", L), mstart, '1);
                    end
                    if (miss_valid && ready) begin
                        cyc    = 0;
                        starts = 0;
                    end
                    if (pend) begin
                        pend = 1'b0;
                        check(pen == 16'(exp_pen[L]), "R9", $sformatf("lane%0d penalty", L), pen, exp_pen[L]);
                        check(ready == 1'b1, "R8", $sformatf("lane%0d ready after done", L), ready, 1);
                    end
                    if (fvalid) begin
                        if (exp_q[L].size() == 0) begin
                            check(1'b0, "R2", $sformatf("lane%0d unexpected word", L), fidx, 0);
                        end else begin
                            e = exp_q[L].pop_front();
                            check(int'(fidx) == e.idx, "R4", $sformatf("lane%0d index", L), fidx, e.idx);
                            check(fdata == e.data, "R3", $sformatf("lane%0d word %0d data", L, e.idx), fdata, e.data);
                            check(cyc == e.cyc, timing_tag(ORG),
                                  $sformatf("lane%0d word %0d cycle", L, e.idx), cyc, e.cyc);
                            check(fdone == (e.idx == W - 1), "R8",
                                  $sformatf("lane%0d done flag word %0d", L, e.idx), fdone, (e.idx == W - 1));
                            if (fdone) begin
                                pend = 1'b1;
                                check(starts == ((ORG == ORG_INTERLEAVED) ? 1 : W), "R10",
                                      $sformatf("lane%0d start count", L), starts,
                                      (ORG == ORG_INTERLEAVED) ? 1 : W);
                            end
                        end
                    end
                end
            end
        end
    endgenerate

    // Driver: present one miss to all copies and push their expectations.
    task automatic issue(logic [31:0] a);
        while (lane_ready != '1) @(posedge clk);
        @(posedge clk);
        #1;
        miss_valid = 1'b1;
        miss_addr  = a;
        for (int l = 0; l < NL; l++) begin
            int          w    = lane_words(l);
            logic [31:0] base = a & ~32'(w * 4 - 1);
            for (int i = 0; i < w; i++) begin
                exp_t e;
                e.idx  = i;
                e.data = mem_word(base + 32'(4 * i));
                e.cyc  = word_cycle(lane_org(l), i);
                exp_q[l].push_back(e);
            end
            exp_pen[l] = word_cycle(lane_org(l), w - 1);
        end
        @(posedge clk);
        #1;
        miss_valid = 1'b0;
    endtask

    task automatic wait_idle();
        bit empty;
        do begin
            @(posedge clk);
            empty = 1'b1;
            for (int l = 0; l < NL; l++) if (exp_q[l].size() != 0) empty = 1'b0;
        end while (!(empty && lane_ready == '1));
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        issue(32'h0000_1000);           // aligned block, R5 R6 R7
        wait_idle();
        issue(32'h1234_567C);           // unaligned miss address, R3
        wait_idle();
        issue(32'hFFFF_FFF0);           // top of the address space, R3
        wait_idle();

        issue(32'h0000_2040);           // requests while busy are ignored, R2
        repeat (5) @(posedge clk);
        #1;
        miss_valid = 1'b1;
        miss_addr  = 32'hDEAD_BEE0;
        repeat (3) @(posedge clk);
        #1;
        miss_valid = 1'b0;
        wait_idle();

        issue(32'h0000_0084);           // back-to-back after idle, R8
        wait_idle();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule